// File: doc/BRIEF.md
# Prioritised Active Interrupt Resolver

This block takes the three pending words of a banked interrupt controller and selects one interrupt to service next. The words are a 21-bit summary word and two 32-bit bank words. The result is a number in a flat space of 72 sources, plus a valid flag. A handler loop pulses the request strobe. One clock later it reads the selected source number, or learns that nothing is left to service.

The search is not a plain priority encode over all 72 sources. It runs in this order:

1. The eight local sources.
2. A fixed list of shortcut flags. These are summary-word copies of selected bank bits, and they are taken in a set order.
3. A lowest-first scan of each bank. The scan only runs when that bank's summary bit is set, and it skips the bank bits that already have a shortcut flag.

Summary word layout:

| Bits | Meaning |
| --- | --- |
| 7:0 | Local sources |
| 8 | Bank 1 has pending bits |
| 9 | Bank 2 has pending bits |
| 14:10 | Shortcuts for bank 1 bits 7, 9, 10, 18, 19, in that order |
| 20:15 | Shortcuts for bank 2 bits 21, 22, 23, 24, 25, 30, in that order |

Top module: `irq_resolve_top`

## Requirements
- R1: Flat numbering: local bit n is number n, bank 1 bit n is 8+n, bank 2 bit n is 40+n.
- R2: If all 21 summary bits are zero, the result is invalid, whatever the bank words hold.
- R3: If any of summary bits 7:0 is set, the result is valid and is the index of the lowest set local bit.
- R4: Otherwise, summary bits 10 to 14 are tested in that order. The first set one gives bank 1 bit 7, 9, 10, 18 or 19, that is, number 15, 17, 18, 26 or 27.
- R5: Otherwise, summary bits 15 to 20 are tested in that order. The first set one gives bank 2 bit 21, 22, 23, 24, 25 or 30, that is, number 61, 62, 63, 64, 65 or 70.
- R6: Otherwise, if summary bit 8 is set, the result is the lowest set bank 1 bit. Bank 1 bits 7, 9, 10, 18 and 19 are ignored in this scan.
- R7: Otherwise, if summary bit 9 is set, the result is the lowest set bank 2 bit. Bank 2 bits 21 to 25 and 30 are ignored in this scan.
- R8: If no rule matches, the result is invalid. Whenever the result is invalid, the number output reads 0.
- R9: Outputs change only on the clock edge that samples the request strobe high. Otherwise they hold, whatever the inputs do.
- R10: While reset is asserted, the outputs are invalid with number 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe; inputs are resolved on this edge |
| basic_i | input | 21 | Summary pending word |
| bank1_i | input | 32 | Bank 1 pending word |
| bank2_i | input | 32 | Bank 2 pending word |
| irq_num_o | output | 7 | Selected interrupt number |
| irq_valid_o | output | 1 | Selected number is valid |

## Verification
The assertions treat the three pending words as unrelated free inputs. No summary bit is assumed to agree with its bank word, and the properties only relate the inputs sampled with a strobe to the registered result one edge later. The stimulus therefore deliberately includes inconsistent cases: summary bits set over empty banks, and bank bits set with no summary bit. Random words are thinned with AND masks so that each priority tier, and not only the local sources, regularly wins.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int unsigned LOCAL_W    = 8;
  localparam int unsigned BANK_W     = 32;
  localparam int unsigned SC1_N      = 5;
  localparam int unsigned SC2_N      = 6;
  localparam int unsigned SUM1_POS   = LOCAL_W;
  localparam int unsigned SUM2_POS   = LOCAL_W + 1;
  localparam int unsigned SC1_LO     = LOCAL_W + 2;
  localparam int unsigned SC2_LO     = SC1_LO + SC1_N;
  localparam int unsigned BASIC_W    = SC2_LO + SC2_N;
  localparam int unsigned BANK1_BASE = LOCAL_W;
  localparam int unsigned BANK2_BASE = LOCAL_W + BANK_W;
  localparam int unsigned NUM_TOTAL  = LOCAL_W + 2 * BANK_W;
  localparam int unsigned NUM_W      = $clog2(NUM_TOTAL);

  // bank bit positions mirrored by shortcut flags, in priority order
  localparam int unsigned SC1_POS [SC1_N] = '{7, 9, 10, 18, 19};
  localparam int unsigned SC2_POS [SC2_N] = '{21, 22, 23, 24, 25, 30};

  typedef logic [NUM_W-1:0] irq_num_t;

  typedef struct packed {
    logic     valid;
    irq_num_t num;
  } irq_res_t;

  function automatic logic [BANK_W-1:0] sc1_excl();
    logic [BANK_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(SC1_N); i++) m[SC1_POS[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [BANK_W-1:0] sc2_excl();
    logic [BANK_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(SC2_N); i++) m[SC2_POS[i]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_lsb_find.sv
module irq_lsb_find #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = int'(W) - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign hit_o = |vec_i;
endmodule

// File: rtl/irq_shortcut_pick.sv
module irq_shortcut_pick
  import irq_res_pkg::*;
#(
  parameter int unsigned N    = 5,
  parameter int unsigned BASE = 8,
  parameter int unsigned POS [N] = '{default: 0}
) (
  input  logic [N-1:0] flag_i,
  output logic         hit_o,
  output irq_num_t     num_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] idx;

  irq_lsb_find #(.W(N), .IW(IW)) u_find (
    .vec_i (flag_i),
    .hit_o (hit_o),
    .idx_o (idx)
  );

  always_comb begin
    num_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (idx == IW'(i)) num_o = NUM_W'(BASE + POS[i]);
    end
  end
endmodule

// File: rtl/irq_bank_scan.sv
module irq_bank_scan
  import irq_res_pkg::*;
#(
  parameter int unsigned           W    = 32,
  parameter int unsigned           BASE = 8,
  parameter logic [W-1:0]          EXCL = '0
) (
  input  logic         en_i,
  input  logic [W-1:0] bank_i,
  output logic         hit_o,
  output irq_num_t     num_o
);
  localparam int unsigned IW = $clog2(W);

  logic [W-1:0]  masked;
  logic          any;
  logic [IW-1:0] idx;

  assign masked = bank_i & ~EXCL;

  irq_lsb_find #(.W(W), .IW(IW)) u_find (
    .vec_i (masked),
    .hit_o (any),
    .idx_o (idx)
  );

  assign hit_o = en_i & any;
  assign num_o = NUM_W'(BASE) + NUM_W'(idx);
endmodule

// File: rtl/irq_resolve_top.sv
module irq_resolve_top
  import irq_res_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [BASIC_W-1:0] basic_i,
  input  logic [BANK_W-1:0]  bank1_i,
  input  logic [BANK_W-1:0]  bank2_i,
  output logic [NUM_W-1:0]   irq_num_o,
  output logic               irq_valid_o
);
  localparam int unsigned LIW = $clog2(LOCAL_W);
  localparam logic [BANK_W-1:0] EXCL1 = sc1_excl();
  localparam logic [BANK_W-1:0] EXCL2 = sc2_excl();

  logic           loc_hit, sc1_hit, sc2_hit, b1_hit, b2_hit;
  logic [LIW-1:0] loc_idx;
  irq_num_t       sc1_num, sc2_num, b1_num, b2_num;
  irq_res_t       pick, res_q;

  irq_lsb_find #(.W(LOCAL_W), .IW(LIW)) u_local (
    .vec_i (basic_i[LOCAL_W-1:0]),
    .hit_o (loc_hit),
    .idx_o (loc_idx)
  );

  irq_shortcut_pick #(.N(SC1_N), .BASE(BANK1_BASE), .POS(SC1_POS)) u_sc1 (
    .flag_i (basic_i[SC1_LO +: SC1_N]),
    .hit_o  (sc1_hit),
    .num_o  (sc1_num)
  );

  irq_shortcut_pick #(.N(SC2_N), .BASE(BANK2_BASE), .POS(SC2_POS)) u_sc2 (
    .flag_i (basic_i[SC2_LO +: SC2_N]),
    .hit_o  (sc2_hit),
    .num_o  (sc2_num)
  );

  irq_bank_scan #(.W(BANK_W), .BASE(BANK1_BASE), .EXCL(EXCL1)) u_bank1 (
    .en_i   (basic_i[SUM1_POS]),
    .bank_i (bank1_i),
    .hit_o  (b1_hit),
    .num_o  (b1_num)
  );

  irq_bank_scan #(.W(BANK_W), .BASE(BANK2_BASE), .EXCL(EXCL2)) u_bank2 (
    .en_i   (basic_i[SUM2_POS]),
    .bank_i (bank2_i),
    .hit_o  (b2_hit),
    .num_o  (b2_num)
  );

  // tiered priority; an all-zero summary word leaves every hit low
  always_comb begin
    pick = '0;
    if (loc_hit)     pick = '{valid: 1'b1, num: NUM_W'(loc_idx)};
    else if (sc1_hit) pick = '{valid: 1'b1, num: sc1_num};
    else if (sc2_hit) pick = '{valid: 1'b1, num: sc2_num};
    else if (b1_hit)  pick = '{valid: 1'b1, num: b1_num};
    else if (b2_hit)  pick = '{valid: 1'b1, num: b2_num};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    res_q <= '0;
    else if (req_i) res_q <= pick;
  end

  assign irq_num_o   = res_q.num;
  assign irq_valid_o = res_q.valid;
endmodule

// File: rtl/irq_resolve_chk.sv
module irq_resolve_chk
  import irq_res_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic [BASIC_W-1:0] basic_i,
  input logic [BANK_W-1:0]  bank1_i,
  input logic [BANK_W-1:0]  bank2_i,
  input logic [NUM_W-1:0]   irq_num_o,
  input logic               irq_valid_o
);
  // R10
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!irq_valid_o && irq_num_o == '0));

  // R9
  hold_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(irq_num_o) && $stable(irq_valid_o)));

  // R2
  empty_summary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && basic_i == '0) |=> !irq_valid_o);

  // R3
  local_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && basic_i[LOCAL_W-1:0] != '0) |=> (irq_valid_o && irq_num_o < NUM_W'(LOCAL_W)));

  // R4
  sc1_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && basic_i[LOCAL_W-1:0] == '0 && basic_i[SC1_LO +: SC1_N] != '0)
    |=> (irq_valid_o && irq_num_o >= NUM_W'(BANK1_BASE) && irq_num_o < NUM_W'(BANK2_BASE)));

  // R5
  sc2_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && basic_i[SC2_LO-1:0] == {SC1_N+2+LOCAL_W{1'b0}} && basic_i[SC2_LO +: SC2_N] != '0)
    |=> (irq_valid_o && irq_num_o >= NUM_W'(BANK2_BASE)));

  // R8
  invalid_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_valid_o |-> irq_num_o == '0);

  // R1
  num_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> irq_num_o < NUM_W'(NUM_TOTAL));
endmodule

bind irq_resolve_top irq_resolve_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .basic_i     (basic_i),
  .bank1_i     (bank1_i),
  .bank2_i     (bank2_i),
  .irq_num_o   (irq_num_o),
  .irq_valid_o (irq_valid_o)
);

// File: tb/irq_resolve_top_tb_top.sv
`timescale 1ns/1ps
module irq_resolve_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [20:0] basic_i = '0;
  logic [31:0] bank1_i = '0;
  logic [31:0] bank2_i = '0;
  logic [6:0]  irq_num_o;
  logic        irq_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  irq_resolve_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .basic_i(basic_i),
    .bank1_i(bank1_i), .bank2_i(bank2_i),
    .irq_num_o(irq_num_o), .irq_valid_o(irq_valid_o)
  );

  // independent reference model: returns {valid, num}
  function automatic logic [7:0] model(logic [20:0] b, logic [31:0] w1, logic [31:0] w2);
    int s1 [5] = '{7, 9, 10, 18, 19};
    int s2 [6] = '{21, 22, 23, 24, 25, 30};
    if (b == 0) return 8'h00;
    for (int i = 0; i < 8; i++) if (b[i]) return {1'b1, 7'(i)};
    for (int i = 0; i < 5; i++) if (b[10+i]) return {1'b1, 7'(8 + s1[i])};
    for (int i = 0; i < 6; i++) if (b[15+i]) return {1'b1, 7'(40 + s2[i])};
    if (b[8]) begin
      for (int n = 0; n < 32; n++) begin
        if (w1[n] && n != 7 && n != 9 && n != 10 && n != 18 && n != 19)
          return {1'b1, 7'(8 + n)};
      end
    end
    if (b[9]) begin
      for (int n = 0; n < 32; n++) begin
        if (w2[n] && !(n >= 21 && n <= 25) && n != 30) return {1'b1, 7'(40 + n)};
      end
    end
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [7:0] exp);
    checks++;
    if ({irq_valid_o, irq_num_o} !== exp) begin
      errors++;
      $display("FAIL %s: got valid=%0b num=%0d, expected valid=%0b num=%0d",
               tag, irq_valid_o, irq_num_o, exp[7], exp[6:0]);
    end
  endtask

  task automatic resolve(string tag, logic [20:0] b, logic [31:0] w1, logic [31:0] w2);
    basic_i = b; bank1_i = w1; bank2_i = w2; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    check(tag, model(b, w1, w2));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R10 reset", 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: empty summary, banks full
    resolve("R2 empty summary", 21'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R2 empty summary exact", 8'h00);
    // R3
    resolve("R3 local lowest", 21'h1FFF_A0 | 21'h0, 32'h0, 32'h0);
    resolve("R3 local bit7", 21'h1FFF80, 32'h1, 32'h1);
    // R4 order: bits 11 and 14 -> bank1 bit 9 -> 17
    resolve("R4 shortcut order", 21'h004800, 32'h0, 32'h0);
    check("R4 expect 17", {1'b1, 7'd17});
    resolve("R4 last shortcut", 21'h004000, 32'h0, 32'h0);
    check("R4 expect 27", {1'b1, 7'd27});
    // R5
    resolve("R5 shortcut order", 21'h110000, 32'h0, 32'h0);
    check("R5 expect 62", {1'b1, 7'd62});
    resolve("R5 bit30", 21'h100300, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R5 expect 70", {1'b1, 7'd70});
    // R6: excluded bank1 bits skipped
    resolve("R6 excl skip", 21'h000100, 32'h0010_0680, 32'h0);
    check("R6 expect 28", {1'b1, 7'd28});
    // R1 numbering boundaries
    resolve("R1 bank1 bit0", 21'h000100, 32'h0000_0001, 32'h0);
    check("R1 expect 8", {1'b1, 7'd8});
    resolve("R1 bank2 bit31", 21'h000200, 32'h0, 32'h8000_0000);
    check("R1 expect 71", {1'b1, 7'd71});
    // R7: excluded bank2 bits, then falls to bit 0 => 40
    resolve("R7 excl skip", 21'h000300, 32'h0000_0680, 32'h43E0_0001);
    check("R7 expect 40", {1'b1, 7'd40});
    // R8: summaries set but only excluded bank bits
    resolve("R8 no match", 21'h000300, 32'h000C_0680, 32'h43E0_0000);
    check("R8 invalid zero", 8'h00);
    resolve("R8 bank bits without summary", 21'h0, 32'h1, 32'h1);

    // R9: hold without request
    resolve("R9 setup", 21'h000004, 32'h0, 32'h0);
    held = {irq_valid_o, irq_num_o};
    basic_i = 21'h0; bank1_i = 32'h1; bank2_i = 32'h1;
    repeat (3) @(negedge clk_i);
    check("R9 hold", held);

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [20:0] b;
      int mode;
      mode = int'($urandom_range(0, 3));
      b = 21'($urandom) & 21'($urandom);
      if (mode >= 1) b[7:0] = '0;
      if (mode >= 2) b[14:10] = '0;
      if (mode >= 3) b[20:15] = '0;
      resolve("R3 R4 R5 R6 R7 random", b, $urandom & $urandom & $urandom,
              $urandom & $urandom & $urandom);
      if ($urandom_range(0, 3) == 0) @(negedge clk_i);
    end

    // R10: reset mid-run
    resolve("R10 pre", 21'h000001, 32'h0, 32'h0);
    rst_ni = 1'b0;
    #1;
    check("R10 async reset", 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule